// File: doc/BRIEF.md
# Calendar Clock with Update Cycle

This block keeps wall-clock time and date: seconds, minutes, hours, day of week, day of month, month, a two-digit year and a separate century byte. A one-cycle enable at 32 768 Hz drives a sub-second phase counter. Each time that counter wraps, the time advances by one second and carries through the Gregorian calendar, including month lengths and leap years with the century rule. Before every update a flag warns firmware that the fields are about to change. After the update a one-cycle pulse marks that it has finished, and a second pulse is gated by an interrupt enable.

Firmware reaches the block through a byte-wide write port and reads every field on parallel output bytes. Two control bytes choose the encoding (packed BCD or binary), the hour form (24-hour, or 12-hour with a PM flag), a set mode that freezes the clock, and a divider field that can run the phase counter, stop it, or hold it in reset. Time is kept in binary internally. The chosen encoding is applied on the way out and removed on the way in, so changing a mode bit converts every field on the next cycle.

Write addresses: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month, 6 year, 7 century, 8 control A, 9 control B. Addresses 10 to 15 are ignored.

Top module: `cal_clock`

## Requirements
- R1: After reset the clock reads 2000-01-01, day of week 1, 00:00:00 (century byte 0x20 in BCD). Control A reads 0x26, control B reads 0x02, and both pulses are low.
- R2: The phase counter advances on each cycle with `tick_i` high while the divider field (control A bits 6:4) is 2 or less. The seconds advance on the TICKS_PER_SEC-th such tick, unless set mode (control B bit 7) is on.
- R3: Control A bit 7 (update in progress) reads 1 during the last UIP_TICKS ticks before each seconds update, and only while the clock runs and set mode is off. It reads 0 once the update is done. Writes cannot change it.
- R4: A divider field of 6 or 7 holds the phase at zero: no update occurs and bit 7 reads 0. Writing a field of 2 or less while the divider is held starts the phase at half a second, so the first update comes TICKS_PER_SEC/2 ticks later. Fields 3 to 5 stop the phase counter without clearing it.
- R5: Control B bit 2 set selects binary fields; clear selects packed BCD, tens in bits 7:4. A change takes effect on all outputs in the next cycle, and writes are decoded in the current encoding.
- R6: Control B bit 1 set selects 24-hour hours (0 to 23). Clear selects 12-hour hours: 1 to 12, with bit 7 set for PM, and both midnight and noon written as 12.
- R7: While set mode is on the time fields do not advance. A write to control B with bit 7 set stores bit 4 (update interrupt enable) as 0.
- R8: Seconds, minutes and hours roll over at 59, 59 and 23. Day of week runs 1 to 7 and advances together with the date.
- R9: The date follows Gregorian month lengths. A year is leap when divisible by 4, except a year 00 whose century is not divisible by 4. Year 99 rolls to 00 and carries into the century, which wraps from 99 to 00.
- R10: A write to a time field shows on the outputs in the next cycle and restarts the sub-second phase at zero. If it coincides with an update, the write wins and no pulse is issued.
- R11: `upd_end_o` is high for exactly one cycle after each applied seconds update. `upd_irq_o` is the same pulse, given only while control B bit 4 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle enable at the 32 768 Hz time-base rate |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register address of the write |
| wr_data_i | input | 8 | Write data, in the current encoding |
| sec_o | output | 8 | Seconds |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Hours, 12-hour form with PM in bit 7 when selected |
| dow_o | output | 8 | Day of week 1 to 7 |
| date_o | output | 8 | Day of month |
| month_o | output | 8 | Month 1 to 12 |
| year_o | output | 8 | Year within the century |
| century_o | output | 8 | Century |
| ctrl_a_o | output | 8 | Control A: update-in-progress in bit 7, divider field in bits 6:4, bits 3:0 stored |
| ctrl_b_o | output | 8 | Control B: set mode bit 7, update interrupt enable bit 4, binary bit 2, 24-hour bit 1 |
| upd_end_o | output | 1 | One-cycle pulse after each seconds update |
| upd_irq_o | output | 1 | Update pulse gated by the interrupt enable |

## Verification
A phase counter that is off by even one tick shows as an update pulse one or two cycles early or late, within a second of the fault. It also shows as a bit 7 window of the wrong length in the cycles just before that pulse. A wrong carry or month-length decision stays hidden until the field crosses its limit, and is then seen on the same edge as the pulse. The date tests therefore load the second before each boundary. An encoding fault in the binary store, or in the conversion on either side of it, shows in the cycle after a mode write or a field write, without waiting for any update.

// File: rtl/cal_clock_pkg.sv
package cal_clock_pkg;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic [7:0] dow;
        logic [7:0] date;
        logic [7:0] mon;
        logic [7:0] year;
        logic [7:0] cent;
    } cal_time_t;

    localparam int NUM_FIELDS = 8;
    localparam int HOUR_IDX   = 2;

    localparam logic [3:0] ADDR_HOUR   = 4'd2;
    localparam logic [3:0] ADDR_LAST_T = 4'd7;
    localparam logic [3:0] ADDR_CTRL_A = 4'd8;
    localparam logic [3:0] ADDR_CTRL_B = 4'd9;

    localparam logic [7:0] CTRL_A_INIT = 8'h26;
    localparam logic [7:0] CTRL_B_INIT = 8'h02;

    function automatic logic [7:0] bin_to_bcd(input logic [7:0] v);
        logic [7:0] tens;
        logic [7:0] ones;
        tens = v / 8'd10;
        ones = v - tens * 8'd10;
        return {tens[3:0], ones[3:0]};
    endfunction

    function automatic logic [7:0] bcd_to_bin(input logic [7:0] v);
        return {4'b0, v[7:4]} * 8'd10 + {4'b0, v[3:0]};
    endfunction

    function automatic logic is_leap(input logic [7:0] yr, input logic [7:0] cent);
        if (yr == 8'd0) return (cent[1:0] == 2'b00);
        return (yr[1:0] == 2'b00);
    endfunction

    function automatic logic [7:0] month_days(input logic [7:0] mon, input logic leap);
        case (mon)
            8'd2:                        return leap ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11:     return 8'd30;
            default:                     return 8'd31;
        endcase
    endfunction

endpackage

// File: rtl/cal_phase.sv
module cal_phase #(
    parameter int TICKS_PER_SEC = 32768,
    parameter int UIP_TICKS     = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic count_en_i,
    input  logic hold_i,
    input  logic half_load_i,
    input  logic zero_load_i,
    output logic wrap_o,
    output logic uip_win_o
);
    localparam int PW = $clog2(TICKS_PER_SEC);
    localparam logic [PW-1:0] LAST    = PW'(TICKS_PER_SEC - 1);
    localparam logic [PW-1:0] HALF    = PW'(TICKS_PER_SEC / 2);
    localparam logic [PW-1:0] WIN_BEG = PW'(TICKS_PER_SEC - UIP_TICKS);

    logic [PW-1:0] ph_d, ph_q;

    assign wrap_o    = tick_i && count_en_i && (ph_q == LAST);
    assign uip_win_o = (ph_q >= WIN_BEG);

    always_comb begin
        ph_d = ph_q;
        if (half_load_i)
            ph_d = HALF;
        else if (zero_load_i || hold_i)
            ph_d = '0;
        else if (count_en_i && tick_i)
            ph_d = (ph_q == LAST) ? '0 : ph_q + PW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
    end
endmodule

// File: rtl/cal_rollover.sv
module cal_rollover
    import cal_clock_pkg::*;
(
    input  cal_time_t cur_i,
    output cal_time_t nxt_o
);
    logic       leap;
    logic [7:0] dim;
    logic       c_min, c_hour, c_day, c_mon, c_year, c_cent;

    always_comb begin
        leap   = is_leap(cur_i.year, cur_i.cent);
        dim    = month_days(cur_i.mon, leap);
        c_min  = (cur_i.sec  >= 8'd59);
        c_hour = c_min  && (cur_i.min  >= 8'd59);
        c_day  = c_hour && (cur_i.hour >= 8'd23);
        c_mon  = c_day  && (cur_i.date >= dim);
        c_year = c_mon  && (cur_i.mon  >= 8'd12);
        c_cent = c_year && (cur_i.year >= 8'd99);

        nxt_o     = cur_i;
        nxt_o.sec = c_min ? 8'd0 : cur_i.sec + 8'd1;
        if (c_min)  nxt_o.min  = (cur_i.min  >= 8'd59) ? 8'd0 : cur_i.min  + 8'd1;
        if (c_hour) nxt_o.hour = (cur_i.hour >= 8'd23) ? 8'd0 : cur_i.hour + 8'd1;
        if (c_day) begin
            nxt_o.dow  = (cur_i.dow >= 8'd7) ? 8'd1 : cur_i.dow + 8'd1;
            nxt_o.date = c_mon ? 8'd1 : cur_i.date + 8'd1;
        end
        if (c_mon)  nxt_o.mon  = c_year ? 8'd1 : cur_i.mon  + 8'd1;
        if (c_year) nxt_o.year = c_cent ? 8'd0 : cur_i.year + 8'd1;
        if (c_cent) nxt_o.cent = (cur_i.cent >= 8'd99) ? 8'd0 : cur_i.cent + 8'd1;
    end
endmodule

// File: rtl/cal_encode.sv
module cal_encode
    import cal_clock_pkg::*;
(
    input  cal_time_t  t_i,
    input  logic       bin_i,
    input  logic       h24_i,
    output logic [7:0] enc_o [NUM_FIELDS]
);
    logic [7:0] fld [NUM_FIELDS];

    assign fld[0] = t_i.sec;
    assign fld[1] = t_i.min;
    assign fld[2] = t_i.hour;
    assign fld[3] = t_i.dow;
    assign fld[4] = t_i.date;
    assign fld[5] = t_i.mon;
    assign fld[6] = t_i.year;
    assign fld[7] = t_i.cent;

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
        if (i == HOUR_IDX) begin : g_hour
            logic [7:0] h12;
            logic       pm;
            always_comb begin
                pm = (fld[i] >= 8'd12);
                if (fld[i] == 8'd0)      h12 = 8'd12;
                else if (fld[i] > 8'd12) h12 = fld[i] - 8'd12;
                else                     h12 = fld[i];
            end
            assign enc_o[i] = h24_i ? (bin_i ? fld[i] : bin_to_bcd(fld[i]))
                                    : ({pm, 7'b0} | (bin_i ? h12 : bin_to_bcd(h12)));
        end else begin : g_plain
            assign enc_o[i] = bin_i ? fld[i] : bin_to_bcd(fld[i]);
        end
    end
endmodule

// File: rtl/cal_clock.sv
module cal_clock
    import cal_clock_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int UIP_TICKS     = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       wr_en_i,
    input  logic [3:0] wr_addr_i,
    input  logic [7:0] wr_data_i,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic [7:0] dow_o,
    output logic [7:0] date_o,
    output logic [7:0] month_o,
    output logic [7:0] year_o,
    output logic [7:0] century_o,
    output logic [7:0] ctrl_a_o,
    output logic [7:0] ctrl_b_o,
    output logic       upd_end_o,
    output logic       upd_irq_o
);
    typedef struct packed {
        cal_time_t  t;
        logic [6:0] ca;
        logic [7:0] cb;
        logic       upd;
        logic       irq;
    } state_t;

    state_t st_d, st_q;

    logic       count_en, hold, set_mode, bin_mode, h24_mode, uie;
    logic       time_wr, wr_a, wr_b, half_load;
    logic       wrap, uip_win, applied;
    logic [7:0] dec_val, dec_hour, h_raw;
    cal_time_t  rolled;
    logic [7:0] enc [NUM_FIELDS];

    assign count_en  = (st_q.ca[6:4] <= 3'd2);
    assign hold      = (st_q.ca[6:5] == 2'b11);
    assign set_mode  = st_q.cb[7];
    assign uie       = st_q.cb[4];
    assign bin_mode  = st_q.cb[2];
    assign h24_mode  = st_q.cb[1];

    assign time_wr   = wr_en_i && (wr_addr_i <= ADDR_LAST_T);
    assign wr_a      = wr_en_i && (wr_addr_i == ADDR_CTRL_A);
    assign wr_b      = wr_en_i && (wr_addr_i == ADDR_CTRL_B);
    assign half_load = wr_a && hold && (wr_data_i[6:4] <= 3'd2);

    cal_phase #(
        .TICKS_PER_SEC(TICKS_PER_SEC),
        .UIP_TICKS    (UIP_TICKS)
    ) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .count_en_i (count_en),
        .hold_i     (hold),
        .half_load_i(half_load),
        .zero_load_i(time_wr),
        .wrap_o     (wrap),
        .uip_win_o  (uip_win)
    );

    cal_rollover u_roll (
        .cur_i(st_q.t),
        .nxt_o(rolled)
    );

    // Incoming data is decoded in the encoding currently selected.
    always_comb begin
        dec_val = bin_mode ? wr_data_i : bcd_to_bin(wr_data_i);
        h_raw   = bin_mode ? {1'b0, wr_data_i[6:0]} : bcd_to_bin({1'b0, wr_data_i[6:0]});
        if (h24_mode)
            dec_hour = dec_val;
        else
            dec_hour = ((h_raw == 8'd12) ? 8'd0 : h_raw) + (wr_data_i[7] ? 8'd12 : 8'd0);
    end

    assign applied = wrap && !set_mode && !time_wr;

    always_comb begin
        st_d     = st_q;
        st_d.upd = applied;
        st_d.irq = applied && uie;
        if (applied)
            st_d.t = rolled;
        if (time_wr) begin
            case (wr_addr_i)
                4'd0:    st_d.t.sec  = dec_val;
                4'd1:    st_d.t.min  = dec_val;
                4'd2:    st_d.t.hour = dec_hour;
                4'd3:    st_d.t.dow  = dec_val;
                4'd4:    st_d.t.date = dec_val;
                4'd5:    st_d.t.mon  = dec_val;
                4'd6:    st_d.t.year = dec_val;
                default: st_d.t.cent = dec_val;
            endcase
        end
        if (wr_a)
            st_d.ca = wr_data_i[6:0];
        if (wr_b) begin
            st_d.cb = wr_data_i;
            if (wr_data_i[7])
                st_d.cb[4] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.t   <= '{sec: 8'd0, min: 8'd0, hour: 8'd0, dow: 8'd1,
                          date: 8'd1, mon: 8'd1, year: 8'd0, cent: 8'd20};
            st_q.ca  <= CTRL_A_INIT[6:0];
            st_q.cb  <= CTRL_B_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    cal_encode u_enc (
        .t_i  (st_q.t),
        .bin_i(bin_mode),
        .h24_i(h24_mode),
        .enc_o(enc)
    );

    assign sec_o     = enc[0];
    assign min_o     = enc[1];
    assign hour_o    = enc[2];
    assign dow_o     = enc[3];
    assign date_o    = enc[4];
    assign month_o   = enc[5];
    assign year_o    = enc[6];
    assign century_o = enc[7];
    assign ctrl_a_o  = {uip_win && count_en && !set_mode, st_q.ca};
    assign ctrl_b_o  = st_q.cb;
    assign upd_end_o = st_q.upd;
    assign upd_irq_o = st_q.irq;
endmodule

// File: rtl/cal_clock_checker.sv
module cal_clock_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en_i,
    input logic [7:0] sec_o,
    input logic [7:0] ctrl_a_o,
    input logic [7:0] ctrl_b_o,
    input logic       upd_end_o,
    input logic       upd_irq_o
);
    assert_uip_low_in_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_a_o[6:5] == 2'b11) |-> !ctrl_a_o[7]);

    assert_no_update_when_stopped_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_a_o[6:4] > 3'd2) |=> !upd_end_o);

    assert_uip_precedes_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
        upd_end_o |-> $past(ctrl_a_o[7]));

    assert_set_freezes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_b_o[7] && !wr_en_i) |=> $stable(sec_o));

    assert_set_drops_uie_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_b_o[7] |-> !ctrl_b_o[4]);

    assert_pulse_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        upd_end_o |=> !upd_end_o);

    assert_irq_within_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        upd_irq_o |-> (upd_end_o && ctrl_b_o[4]));
endmodule

bind cal_clock cal_clock_checker u_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en_i  (wr_en_i),
    .sec_o    (sec_o),
    .ctrl_a_o (ctrl_a_o),
    .ctrl_b_o (ctrl_b_o),
    .upd_end_o(upd_end_o),
    .upd_irq_o(upd_irq_o)
);

// File: tb/cal_clock_bench.sv
`timescale 1ns/1ps
module cal_clock_bench;
    localparam int T = 64;
    localparam int U = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o, century_o;
    logic [7:0] ctrl_a_o, ctrl_b_o;
    logic       upd_end_o, upd_irq_o;

    int n_cmp = 0;
    int n_bad = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;
    always @(negedge clk) tick <= ~tick;

    cal_clock #(.TICKS_PER_SEC(T), .UIP_TICKS(U)) u_cal_clock (
        .clk(clk), .rst_n(rst_n), .tick_i(tick),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o),
        .date_o(date_o), .month_o(month_o), .year_o(year_o), .century_o(century_o),
        .ctrl_a_o(ctrl_a_o), .ctrl_b_o(ctrl_b_o),
        .upd_end_o(upd_end_o), .upd_irq_o(upd_irq_o)
    );

    // ---------------- reference model ----------------
    int m_t [8];
    int m_ca, m_cb, m_ph;
    bit m_upd, m_irq;

    function automatic int enc(int v);
        if ((m_cb & 4) != 0) return v;
        return (v / 10) * 16 + (v % 10);
    endfunction

    function automatic int dec(int v);
        if ((m_cb & 4) != 0) return v;
        return (v / 16) * 10 + (v % 16);
    endfunction

    function automatic int enc_hour(int h);
        int h12;
        if ((m_cb & 2) != 0) return enc(h);
        h12 = (h % 12 == 0) ? 12 : h % 12;
        return enc(h12) + ((h >= 12) ? 128 : 0);
    endfunction

    function automatic int dec_hour(int v);
        int h;
        if ((m_cb & 2) != 0) return dec(v);
        h = dec(v % 128);
        if (h == 12) h = 0;
        return h + ((v >= 128) ? 12 : 0);
    endfunction

    function automatic int days_of(int mon, int full_year);
        bit leap;
        leap = ((full_year % 4 == 0) && (full_year % 100 != 0)) || (full_year % 400 == 0);
        if (mon == 2) return leap ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    task automatic model_advance();
        m_t[0]++;
        if (m_t[0] < 60) return;
        m_t[0] = 0; m_t[1]++;
        if (m_t[1] < 60) return;
        m_t[1] = 0; m_t[2]++;
        if (m_t[2] < 24) return;
        m_t[2] = 0;
        m_t[3] = (m_t[3] >= 7) ? 1 : m_t[3] + 1;
        m_t[4]++;
        if (m_t[4] <= days_of(m_t[5], m_t[7] * 100 + m_t[6])) return;
        m_t[4] = 1; m_t[5]++;
        if (m_t[5] <= 12) return;
        m_t[5] = 1; m_t[6]++;
        if (m_t[6] < 100) return;
        m_t[6] = 0; m_t[7] = (m_t[7] + 1) % 100;
    endtask

    task automatic cmp(string name, logic [7:0] got, int exp);
        n_cmp++;
        if (got !== 8'(exp)) begin
            n_bad++;
            $display("FAIL %s %s: got %02h expected %02h at %0t", cur_req, name, got, 8'(exp), $time);
        end
    endtask

    always @(posedge clk) begin
        int  div;
        bit  wrap, twr, setm;
        if (!rst_n) begin
            m_t = '{0, 0, 0, 1, 1, 1, 0, 20};
            m_ca = 'h26; m_cb = 'h02; m_ph = 0; m_upd = 0; m_irq = 0;
        end else begin
            div  = (m_ca / 16) % 8;
            setm = (m_cb & 128) != 0;
            wrap = tick && div <= 2 && m_ph == T - 1;
            twr  = wr_en && int'(wr_addr) <= 7;
            if (wr_en && wr_addr == 8 && div >= 6 && ((int'(wr_data) / 16) % 8) <= 2) m_ph = T / 2;
            else if (twr || div >= 6) m_ph = 0;
            else if (div <= 2 && tick) m_ph = (m_ph + 1) % T;
            m_upd = wrap && !setm && !twr;
            m_irq = m_upd && ((m_cb & 16) != 0);
            if (m_upd) model_advance();
            if (twr) m_t[wr_addr] = (wr_addr == 2) ? dec_hour(int'(wr_data)) : dec(int'(wr_data));
            if (wr_en && wr_addr == 8) m_ca = int'(wr_data) % 128;
            if (wr_en && wr_addr == 9) m_cb = (wr_data[7]) ? (int'(wr_data) & 'hEF) : int'(wr_data);
        end
        #1;
        // time fields: R8 (clock part) and R9 (date part)
        cmp("sec R8",     sec_o,     enc(m_t[0]));
        cmp("min R8",     min_o,     enc(m_t[1]));
        cmp("hour R8",    hour_o,    enc_hour(m_t[2]));
        cmp("dow R8",     dow_o,     enc(m_t[3]));
        cmp("date R9",    date_o,    enc(m_t[4]));
        cmp("month R9",   month_o,   enc(m_t[5]));
        cmp("year R9",    year_o,    enc(m_t[6]));
        cmp("century R9", century_o, enc(m_t[7]));
        cmp("ctrl_a R3",  ctrl_a_o,  m_ca + ((((m_ca / 16) % 8) <= 2 && (m_cb & 128) == 0 && m_ph >= T - U) ? 128 : 0));
        cmp("ctrl_b R7",  ctrl_b_o,  m_cb);
        cmp("upd_end R11", {7'b0, upd_end_o}, int'(m_upd));
        cmp("upd_irq R11", {7'b0, upd_irq_o}, int'(m_irq));
    end

    // ---------------- directed helpers ----------------
    task automatic chk(string req, string what, int got, int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h at %0t", req, what, got, exp, $time);
        end
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_pulse(output int n);
        n = 0;
        do begin
            @(posedge clk); #1; n++;
        end while (!upd_end_o && n < 400);
    endtask

    task automatic set_dt(int c, int y, int mo, int d, int h, int mi, int s);
        int n;
        wr(9, 'h82);
        wr(7, c); wr(6, y); wr(5, mo); wr(4, d); wr(2, h); wr(1, mi); wr(0, s);
        wr(9, 'h12);
        wait_pulse(n);
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int n, pulses;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "sec", sec_o, 'h00);
        chk("R1", "date", date_o, 'h01);
        chk("R1", "century", century_o, 'h20);
        chk("R1", "ctrl_a", ctrl_a_o, 'h26);
        chk("R1", "ctrl_b", ctrl_b_o, 'h02);

        // R2 / R11 free running with interrupt enabled
        cur_req = "R2";
        wr(9, 'h12);
        wait_pulse(n); wait_pulse(n); wait_pulse(n);
        chk("R2", "sec after three updates", sec_o, 'h03);
        chk("R11", "irq with pulse", upd_irq_o, 1);
        @(posedge clk); #1;
        chk("R11", "pulse one cycle", upd_end_o, 0);

        // R8 day rollover
        cur_req = "R8";
        wr(2, 'h23); wr(1, 'h59); wr(0, 'h58);
        wait_pulse(n); wait_pulse(n);
        chk("R8", "hour wrap", hour_o, 'h00);
        chk("R8", "dow advance", dow_o, 'h02);
        chk("R8", "date advance", date_o, 'h02);

        // R7 set mode
        cur_req = "R7";
        wr(9, 'h92);
        chk("R7", "uie forced low", ctrl_b_o, 'h82);
        wr(0, 'h33);
        repeat (200) @(negedge clk);
        chk("R7", "frozen sec", sec_o, 'h33);

        // R9 calendar boundaries
        cur_req = "R9";
        set_dt('h19, 'h99, 'h12, 'h31, 'h23, 'h59, 'h59);
        chk("R9", "year wrap", year_o, 'h00);
        chk("R9", "century carry", century_o, 'h20);
        chk("R9", "month wrap", month_o, 'h01);
        set_dt('h20, 'h00, 'h02, 'h28, 'h23, 'h59, 'h59);
        chk("R9", "2000 leap", date_o, 'h29);
        set_dt('h21, 'h00, 'h02, 'h28, 'h23, 'h59, 'h59);
        chk("R9", "2100 not leap", month_o, 'h03);
        set_dt('h20, 'h23, 'h02, 'h28, 'h23, 'h59, 'h59);
        chk("R9", "2023 not leap", date_o, 'h01);
        set_dt('h20, 'h24, 'h02, 'h29, 'h23, 'h59, 'h59);
        chk("R9", "2024 leap end", month_o, 'h03);
        set_dt('h20, 'h24, 'h04, 'h30, 'h23, 'h59, 'h59);
        chk("R9", "30-day month", month_o, 'h05);
        set_dt('h99, 'h99, 'h12, 'h31, 'h23, 'h59, 'h59);
        chk("R9", "century wrap", century_o, 'h00);

        // R5 encoding switch
        cur_req = "R5";
        wr(9, 'h16);
        wr(0, 42);
        chk("R5", "binary sec", sec_o, 'h2A);
        wr(9, 'h12);
        chk("R5", "bcd sec", sec_o, 'h42);

        // R6 hour forms
        cur_req = "R6";
        wr(1, 'h00); wr(0, 'h00);
        wr(9, 'h10);
        wr(2, 'h92);
        chk("R6", "noon 12h", hour_o, 'h92);
        wr(9, 'h12);
        chk("R6", "noon 24h", hour_o, 'h12);
        wr(9, 'h10);
        wr(2, 'h12);
        chk("R6", "midnight 12h", hour_o, 'h12);
        wr(9, 'h12);
        chk("R6", "midnight 24h", hour_o, 'h00);
        wr(9, 'h14);
        wr(2, 'h81);
        chk("R6", "1pm binary 12h", hour_o, 'h81);
        wr(9, 'h16);
        chk("R6", "13 binary 24h", hour_o, 'h0D);
        wr(9, 'h12);
        chk("R6", "13 bcd 24h", hour_o, 'h13);

        // R4 divider hold and release
        cur_req = "R4";
        wr(8, 'h66);
        pulses = 0;
        for (int i = 0; i < 300; i++) begin
            @(posedge clk); #1;
            if (upd_end_o) pulses++;
        end
        chk("R4", "no pulse in hold", pulses, 0);
        chk("R4", "uip low in hold", ctrl_a_o, 'h66);
        wr(8, 'h26);
        wait_pulse(n);
        chk("R4", "half-second start", int'(n >= 60 && n <= 68), 1);
        wr(8, 'h46);
        pulses = 0;
        for (int i = 0; i < 200; i++) begin
            @(posedge clk); #1;
            if (upd_end_o) pulses++;
        end
        chk("R4", "stopped divider", pulses, 0);
        wr(8, 'h26);

        // R10 write restarts phase
        cur_req = "R10";
        wait_pulse(n);
        repeat (20) @(negedge clk);
        wr(0, 'h10);
        chk("R10", "write visible", sec_o, 'h10);
        wait_pulse(n);
        chk("R10", "full second after write", int'(n >= 124 && n <= 132), 1);

        // R3 update-in-progress window
        cur_req = "R3";
        n = 0;
        do begin @(posedge clk); #1; n++; end while (!ctrl_a_o[7] && n < 400);
        wait_pulse(n);
        chk("R3", "uip window length", int'(n >= 14 && n <= 17), 1);
        chk("R3", "uip cleared after update", ctrl_a_o[7], 0);
        wr(8, 'hA6);
        chk("R3", "bit7 not writable", ctrl_a_o & 'h7F, 'h26);

        repeat (10) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule